// File: doc/BRIEF.md
# Page Descriptor Permission Checker

This block decides whether one memory access may go ahead. It takes the attribute bits of a final long-format translation descriptor and the attributes gathered from the table levels above it. From these it computes read, write and execute rights for the current access and reports a permission fault when the access needs a right it does not have. The result comes out one clock after the request.

The execute right depends on several things: the exception level (0, 1 or 3), whether the controlling level runs in 64-bit or 32-bit state, and whether the core is in secure state. Four rules apply together: write-implies-never-execute (WXN), implied privileged never-execute for pages that user code can write, the 32-bit user-writable never-execute control, and the secure fetch restriction on non-secure memory. A request at exception level 2 is not handled. It is flagged as unsupported.

Top module: `permchk_top`

## Requirements
- R1: `rspValid` equals `reqValid` from the previous clock. While `rspValid` is 0, all permission, fault and unsupported outputs are 0. Reset clears all outputs.
- R2: Descriptor attribute bits [5:4] are AP[2:1]. When the access is unprivileged (`isUser`=1) and AP[1] (bit 4) is 0, all permissions are 0 and a fault of kind 1 is raised, whatever the access type.
- R3: Once the check in R2 passes, read permission is 1. Write permission is 1 exactly when AP[2] (bit 5) is 0.
- R4: Access type encoding is 0 read, 1 write, 2 instruction fetch, 3 treated as read. A write without write permission raises a fault of kind 2.
- R5: A fetch without execute permission raises a fault of kind 3. Without any fault, `rspKind` is 0.
- R6: At EL0/EL1 in 64-bit state, PXN (bit 11) is forced to 1 when the page is user-writable (bit 4 = 1, bit 5 = 0). A user access is then barred from executing by UXN (bit 12), and a privileged access by the forced PXN.
- R7: At EL0/EL1 in 32-bit state, PXN is forced to 1 only when `sctlrUwxnEl1` is set and the page is user-writable. A privileged access is barred by XN (bit 12) or the effective PXN. A user access is barred by XN alone.
- R8: The effective NS bit is descriptor bit 3 OR table attribute bit 4. When it is 1 and `scrSif` is 1, execution is denied in secure state at EL0/EL1 and always at EL3. In non-secure state at EL0/EL1, `scrSif` has no effect.
- R9: A page writable at AP[2]=0 is not executable when WXN is active. WXN is `sctlrWxnEl1` at EL0/EL1. At EL3 it is `sctlrWxnEl3` when EL3 runs in 64-bit state, and 0 otherwise.
- R10: A request with `reqEl`=2 returns `rspUnsupported`=1, all permissions 0, and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request strobe |
| reqEl | input | 2 | Current exception level |
| ctlIs64 | input | 1 | Controlling level (EL1 for EL0/EL1, EL3 for EL3) runs in 64-bit state |
| secure | input | 1 | Core is in secure state |
| accType | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| isUser | input | 1 | Unprivileged access |
| descAttr | input | ATTR_W | Final descriptor attribute bits |
| tableAttr | input | TBL_W | Accumulated table attributes |
| sctlrWxnEl1 | input | 1 | WXN control of EL1 |
| sctlrUwxnEl1 | input | 1 | User-writable never-execute control (32-bit) |
| sctlrWxnEl3 | input | 1 | WXN control of EL3 |
| scrSif | input | 1 | Secure fetch restriction enable |
| rspValid | output | 1 | Response strobe |
| rspRead | output | 1 | Read permitted |
| rspWrite | output | 1 | Write permitted |
| rspExec | output | 1 | Execute permitted |
| rspFault | output | 1 | Permission fault |
| rspKind | output | 2 | 0 none, 1 unprivileged, 2 write, 3 fetch |
| rspUnsupported | output | 1 | Exception level 2 request |

## Verification
Each execute-never source is driven with the others held clear: UXN, PXN, forced PXN, UWXN, NS with SIF, and WXN. The same descriptor is then applied with only the privilege, the execution width or the secure state changed. This separates the 64-bit user/privileged split from the 32-bit OR of XN and PXN, and the NS-from-descriptor path from the NS-from-table path. WXN is exercised at EL3 in both widths and with the EL1 control set, which shows that the correct control bit is selected per level. Write and fetch faults are tried against both permitted and denied pages, and the reserved access type against a read-only page.

// File: rtl/permchk_pkg.sv
package permchk_pkg;
  localparam int NS_BIT    = 3;
  localparam int AP1_BIT   = 4;
  localparam int AP2_BIT   = 5;
  localparam int PXN_BIT   = 11;
  localparam int XN_BIT    = 12;
  localparam int NSTBL_BIT = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_UNPRIV = 2'd1,
    FLT_WRITE  = 2'd2,
    FLT_FETCH  = 2'd3
  } faultKind_e;

  typedef struct packed {
    logic el01Rules;
    logic badEl;
    logic wide64;
    logic wantWrite;
    logic wantFetch;
    logic sifActive;
    logic wxnActive;
  } ctlStrobes_t;
endpackage

// File: rtl/permchk_control.sv
module permchk_control
  import permchk_pkg::*;
(
  input  logic [1:0]  reqEl,
  input  logic        ctlIs64,
  input  logic        secure,
  input  logic [1:0]  accType,
  input  logic        sctlrWxnEl1,
  input  logic        sctlrWxnEl3,
  input  logic        scrSif,
  output ctlStrobes_t ctl
);
  accKind_e acc;
  logic     atEl01, atEl3;

  always_comb begin
    acc    = accKind_e'(accType);
    atEl01 = (reqEl == 2'd0) || (reqEl == 2'd1);
    atEl3  = (reqEl == 2'd3);

    ctl.el01Rules = atEl01;
    ctl.badEl     = (reqEl == 2'd2);
    ctl.wide64    = ctlIs64;
    ctl.wantWrite = (acc == ACC_WRITE);
    ctl.wantFetch = (acc == ACC_FETCH);
    ctl.sifActive = scrSif && ((atEl01 && secure) || atEl3);
    if (atEl01)
      ctl.wxnActive = sctlrWxnEl1;
    else if (atEl3)
      ctl.wxnActive = ctlIs64 && sctlrWxnEl3;
    else
      ctl.wxnActive = 1'b0;
  end
endmodule

// File: rtl/permchk_datapath.sv
module permchk_datapath
  import permchk_pkg::*;
#(
  parameter int ATTR_W = 13,
  parameter int TBL_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  ctlStrobes_t       ctl,
  input  logic              isUser,
  input  logic              sctlrUwxnEl1,
  input  logic [ATTR_W-1:0] descAttr,
  input  logic [TBL_W-1:0]  tableAttr,
  output logic              rspValid,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec,
  output logic              rspFault,
  output logic [1:0]        rspKind,
  output logic              rspUnsupported
);
  logic ap1, ap2, nsEff, pxnRaw, xnRaw, userWritable;
  logic pxnEff, xnEff, canExec, unprivDenied;
  logic nextRead, nextWrite, nextExec;
  faultKind_e nextKind;

  always_comb begin
    ap1          = descAttr[AP1_BIT];
    ap2          = descAttr[AP2_BIT];
    nsEff        = descAttr[NS_BIT] | tableAttr[NSTBL_BIT];
    pxnRaw       = descAttr[PXN_BIT];
    xnRaw        = descAttr[XN_BIT];
    userWritable = ap1 & ~ap2;

    pxnEff = pxnRaw;
    xnEff  = xnRaw;
    if (ctl.el01Rules) begin
      if (ctl.wide64) begin
        pxnEff = pxnRaw | userWritable;
        xnEff  = isUser ? xnRaw : pxnEff;
      end else begin
        pxnEff = pxnRaw | (sctlrUwxnEl1 & userWritable);
        xnEff  = xnRaw | (~isUser & pxnEff);
      end
    end
    if (ctl.sifActive && nsEff) xnEff = 1'b1;

    canExec      = ~xnEff & ~(~ap2 & ctl.wxnActive);
    unprivDenied = isUser & ~ap1;

    if (ctl.badEl || unprivDenied) begin
      nextRead  = 1'b0;
      nextWrite = 1'b0;
      nextExec  = 1'b0;
    end else begin
      nextRead  = 1'b1;
      nextWrite = ~ap2;
      nextExec  = canExec;
    end

    if (ctl.badEl)                       nextKind = FLT_NONE;
    else if (unprivDenied)               nextKind = FLT_UNPRIV;
    else if (ctl.wantWrite && ap2)       nextKind = FLT_WRITE;
    else if (ctl.wantFetch && !canExec)  nextKind = FLT_FETCH;
    else                                 nextKind = FLT_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid       <= 1'b0;
      rspRead        <= 1'b0;
      rspWrite       <= 1'b0;
      rspExec        <= 1'b0;
      rspFault       <= 1'b0;
      rspKind        <= 2'd0;
      rspUnsupported <= 1'b0;
    end else begin
      rspValid       <= reqValid;
      rspRead        <= reqValid & nextRead;
      rspWrite       <= reqValid & nextWrite;
      rspExec        <= reqValid & nextExec;
      rspFault       <= reqValid & (nextKind != FLT_NONE);
      rspKind        <= reqValid ? nextKind : FLT_NONE;
      rspUnsupported <= reqValid & ctl.badEl;
    end
  end
endmodule

// File: rtl/permchk_top.sv
module permchk_top
  import permchk_pkg::*;
#(
  parameter int ATTR_W = 13,
  parameter int TBL_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqEl,
  input  logic              ctlIs64,
  input  logic              secure,
  input  logic [1:0]        accType,
  input  logic              isUser,
  input  logic [ATTR_W-1:0] descAttr,
  input  logic [TBL_W-1:0]  tableAttr,
  input  logic              sctlrWxnEl1,
  input  logic              sctlrUwxnEl1,
  input  logic              sctlrWxnEl3,
  input  logic              scrSif,
  output logic              rspValid,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec,
  output logic              rspFault,
  output logic [1:0]        rspKind,
  output logic              rspUnsupported
);
  ctlStrobes_t ctl;

  permchk_control u_ctl (
    .reqEl(reqEl), .ctlIs64(ctlIs64), .secure(secure), .accType(accType),
    .sctlrWxnEl1(sctlrWxnEl1), .sctlrWxnEl3(sctlrWxnEl3), .scrSif(scrSif),
    .ctl(ctl)
  );

  permchk_datapath #(.ATTR_W(ATTR_W), .TBL_W(TBL_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ctl(ctl), .isUser(isUser),
    .sctlrUwxnEl1(sctlrUwxnEl1), .descAttr(descAttr), .tableAttr(tableAttr),
    .rspValid(rspValid), .rspRead(rspRead), .rspWrite(rspWrite),
    .rspExec(rspExec), .rspFault(rspFault), .rspKind(rspKind),
    .rspUnsupported(rspUnsupported)
  );
endmodule

// File: rtl/permchk_checker.sv
module permchk_checker #(
  parameter int ATTR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqEl,
  input logic              isUser,
  input logic [ATTR_W-1:0] descAttr,
  input logic              rspValid,
  input logic              rspRead,
  input logic              rspWrite,
  input logic              rspExec,
  input logic              rspFault,
  input logic [1:0]        rspKind,
  input logic              rspUnsupported
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspRead || rspWrite || rspExec || rspFault || rspUnsupported));
  assert_unpriv_fault_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isUser && !descAttr[4] && reqEl != 2'd2)
      |=> (rspFault && rspKind == 2'd1 && !rspRead && !rspWrite && !rspExec));
  assert_write_needs_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspWrite |-> rspRead);
  assert_write_fault_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault && rspKind == 2'd2) |-> !rspWrite);
  assert_fetch_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault && rspKind == 2'd3) |-> !rspExec);
  assert_unsupported_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqEl == 2'd2)
      |=> (rspUnsupported && !rspFault && !rspRead && !rspWrite && !rspExec));
endmodule

bind permchk_top permchk_checker #(.ATTR_W(ATTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEl(reqEl), .isUser(isUser),
  .descAttr(descAttr), .rspValid(rspValid), .rspRead(rspRead),
  .rspWrite(rspWrite), .rspExec(rspExec), .rspFault(rspFault),
  .rspKind(rspKind), .rspUnsupported(rspUnsupported)
);

// File: tb/permchk_top_test.sv
module permchk_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqEl = 2'd1;
  logic ctlIs64 = 1'b1, secure = 1'b0, isUser = 1'b0;
  logic [1:0] accType = 2'd0;
  logic [12:0] descAttr = '0;
  logic [4:0] tableAttr = '0;
  logic sctlrWxnEl1 = 0, sctlrUwxnEl1 = 0, sctlrWxnEl3 = 0, scrSif = 0;
  logic rspValid, rspRead, rspWrite, rspExec, rspFault, rspUnsupported;
  logic [1:0] rspKind;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  permchk_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEl(reqEl),
    .ctlIs64(ctlIs64), .secure(secure), .accType(accType), .isUser(isUser),
    .descAttr(descAttr), .tableAttr(tableAttr), .sctlrWxnEl1(sctlrWxnEl1),
    .sctlrUwxnEl1(sctlrUwxnEl1), .sctlrWxnEl3(sctlrWxnEl3), .scrSif(scrSif),
    .rspValid(rspValid), .rspRead(rspRead), .rspWrite(rspWrite),
    .rspExec(rspExec), .rspFault(rspFault), .rspKind(rspKind),
    .rspUnsupported(rspUnsupported)
  );

  // {ap2, ap1, ns, pxn, xn} -> attribute bits 5,4,3,11,12
  function automatic logic [12:0] mk(bit ap2, bit ap1, bit ns, bit pxn, bit xn);
    logic [12:0] a = '0;
    a[5] = ap2; a[4] = ap1; a[3] = ns; a[11] = pxn; a[12] = xn;
    return a;
  endfunction

  // expected packing: {valid, read, write, exec, fault, kind[1:0], unsupported}
  task automatic expect8(string tag, logic [7:0] exp);
    logic [7:0] act;
    act = {rspValid, rspRead, rspWrite, rspExec, rspFault, rspKind, rspUnsupported};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic defaults();
    reqEl = 2'd1; ctlIs64 = 1; secure = 0; isUser = 0; accType = 2'd0;
    descAttr = '0; tableAttr = '0;
    sctlrWxnEl1 = 0; sctlrUwxnEl1 = 0; sctlrWxnEl3 = 0; scrSif = 0;
  endtask

  // called at a negedge; drives, lets one posedge pass, samples at next negedge
  task automatic issue(string tag, logic [7:0] exp);
    reqValid = 1'b1;
    @(negedge clk);
    expect8(tag, exp);
    defaults();
  endtask

  task automatic test_reset();
    expect8("R1 reset state", 8'b0000_0000);
    reqValid = 1'b0;
    @(negedge clk);
    expect8("R1 idle after reset", 8'b0000_0000);
  endtask

  task automatic test_unpriv();
    isUser = 1; descAttr = mk(0, 0, 0, 0, 0);
    issue("R2 user read AP1=0", 8'b1000_1010);
    isUser = 1; descAttr = mk(0, 0, 0, 0, 0); accType = 2'd2;
    issue("R2 user fetch AP1=0", 8'b1000_1010);
  endtask

  task automatic test_rw();
    accType = 2'd1; descAttr = mk(0, 0, 0, 0, 0);
    issue("R3 priv write to writable page", 8'b1111_0000);
    accType = 2'd1; descAttr = mk(1, 0, 0, 0, 0);
    issue("R4 priv write to read-only page", 8'b1101_1100);
    accType = 2'd3; descAttr = mk(1, 0, 0, 0, 0);
    issue("R4 reserved type acts as read", 8'b1101_0000);
  endtask

  task automatic test_fetch();
    accType = 2'd2; descAttr = mk(1, 0, 0, 1, 0);
    issue("R5 fetch with PXN", 8'b1100_1110);
    accType = 2'd0; descAttr = mk(1, 0, 0, 1, 0);
    issue("R5 read with PXN no fault", 8'b1100_0000);
  endtask

  task automatic test_a64();
    descAttr = mk(0, 1, 0, 0, 0);
    issue("R6 priv on user-writable page", 8'b1110_0000);
    isUser = 1; descAttr = mk(0, 1, 0, 0, 0);
    issue("R6 user on user-writable page", 8'b1111_0000);
    isUser = 1; descAttr = mk(1, 1, 0, 0, 1);
    issue("R6 user with UXN", 8'b1100_0000);
    descAttr = mk(1, 0, 0, 0, 1);
    issue("R6 priv ignores UXN", 8'b1101_0000);
  endtask

  task automatic test_a32();
    ctlIs64 = 0; descAttr = mk(0, 1, 0, 0, 0);
    issue("R7 user-writable without UWXN", 8'b1111_0000);
    ctlIs64 = 0; sctlrUwxnEl1 = 1; descAttr = mk(0, 1, 0, 0, 0);
    issue("R7 user-writable with UWXN", 8'b1110_0000);
    ctlIs64 = 0; descAttr = mk(1, 0, 0, 0, 1);
    issue("R7 priv with XN", 8'b1100_0000);
    ctlIs64 = 0; isUser = 1; descAttr = mk(1, 1, 0, 1, 0);
    issue("R7 user ignores PXN", 8'b1101_0000);
  endtask

  task automatic test_sif();
    secure = 1; scrSif = 1; descAttr = mk(1, 0, 1, 0, 0);
    issue("R8 secure NS page SIF", 8'b1100_0000);
    secure = 1; scrSif = 1; descAttr = mk(1, 0, 0, 0, 0); tableAttr = 5'b10000;
    issue("R8 NS from table attr", 8'b1100_0000);
    secure = 1; scrSif = 0; descAttr = mk(1, 0, 1, 0, 0);
    issue("R8 secure NS page no SIF", 8'b1101_0000);
    scrSif = 1; descAttr = mk(1, 0, 1, 0, 0);
    issue("R8 nonsecure SIF ignored", 8'b1101_0000);
    reqEl = 2'd3; scrSif = 1; descAttr = mk(1, 0, 1, 0, 0);
    issue("R8 EL3 NS page SIF", 8'b1100_0000);
  endtask

  task automatic test_wxn();
    sctlrWxnEl1 = 1; descAttr = mk(0, 0, 0, 0, 0);
    issue("R9 EL1 WXN writable", 8'b1110_0000);
    sctlrWxnEl1 = 1; descAttr = mk(1, 0, 0, 0, 0);
    issue("R9 EL1 WXN read-only", 8'b1101_0000);
    reqEl = 2'd3; sctlrWxnEl3 = 1; descAttr = mk(0, 0, 0, 0, 0);
    issue("R9 EL3 64-bit WXN", 8'b1110_0000);
    reqEl = 2'd3; ctlIs64 = 0; sctlrWxnEl3 = 1; descAttr = mk(0, 0, 0, 0, 0);
    issue("R9 EL3 32-bit WXN ignored", 8'b1111_0000);
    reqEl = 2'd3; sctlrWxnEl1 = 1; descAttr = mk(0, 0, 0, 0, 0);
    issue("R9 EL3 ignores EL1 WXN", 8'b1111_0000);
  endtask

  task automatic test_el2();
    reqEl = 2'd2; accType = 2'd1; descAttr = mk(1, 0, 0, 0, 0);
    issue("R10 EL2 unsupported", 8'b1000_0001);
    reqValid = 1'b0;
    @(negedge clk);
    expect8("R1 valid drops after idle", 8'b0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_unpriv();
    test_rw();
    test_fetch();
    test_a64();
    test_a32();
    test_sif();
    test_wxn();
    test_el2();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule